// File: doc/BRIEF.md
# AXI-Stream Handshake Protocol Monitor

This block sits passively on a single AXI-Stream link. It watches the valid, ready and data wires but never drives them. It checks the two stability rules that bind the transmitter during a stall. Once valid is raised and not yet accepted, valid must stay high and the data must hold its value until the transfer completes. A broken rule raises a one-cycle error pulse that carries a cause code, and it also sets a sticky error flag.

The block also gives visibility into how the link was exercised. It counts completed transfers. It counts stalls caused by the receiver (backpressure) and stalls caused by the transmitter (throttling). It also counts the cases where the receiver withdraws ready before any transfer took place, which the protocol allows. Every counter saturates at its maximum value. A synchronous clear input zeroes the counters and the error state, so a test or a system phase can measure a window of traffic.

Top module: `axis_hs_monitor`

## Requirements
- R1: Each rising edge with `tValid` and `tReady` both high adds one to `xferCount`, visible after that edge.
- R2: If the previous edge sampled `tValid=1, tReady=0` and the current edge samples `tValid=0`, then after the current edge `errPulse` is high for one cycle and `errCause[0]` (valid dropped) is set.
- R3: If the previous edge sampled `tValid=1, tReady=0` and the current edge samples `tData` different from the previous sample, then `errPulse` rises after the current edge with `errCause[1]` (data changed) set. Both violations together give `errCause=2'b11`. When `errPulse` is low, `errCause` is `2'b00`.
- R4: The receiver may toggle `tReady` while `tValid` is low. Valid may come before ready, after it, or in the same cycle. Legal traffic that keeps valid and data stable across stalls never raises `errPulse` or `errSticky`.
- R5: Each edge sampling `tValid=1, tReady=0` adds one to `bpStallCount`.
- R6: Each edge sampling `tValid=0, tReady=1` adds one to `thrStallCount`.
- R7: An edge sampling `tReady=0`, directly after an edge that sampled `tValid=0, tReady=1`, adds one to `retractCount`.
- R8: `errSticky` goes high together with any `errPulse`. It stays high until `clear` or reset, regardless of the traffic that follows.
- R9: Every counter stops at all ones (65535 by default) instead of wrapping.
- R10: An edge with `clear` high zeroes all counters, `errSticky`, `errPulse` and `errCause`. Events sampled on that edge are discarded.
- R11: During and right after reset, all outputs are zero. The first edge after reset can raise no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of counters and error state |
| tValid | input | 1 | Observed valid from the transmitter |
| tReady | input | 1 | Observed ready from the receiver |
| tData | input | DATA_W | Observed payload |
| errSticky | output | 1 | Set on any violation, held until clear or reset |
| errPulse | output | 1 | One-cycle violation strobe |
| errCause | output | 2 | Bit 0 valid dropped, bit 1 data changed |
| xferCount | output | CNT_W | Completed transfers, saturating |
| bpStallCount | output | CNT_W | Backpressure stall cycles, saturating |
| thrStallCount | output | CNT_W | Throttling stall cycles, saturating |
| retractCount | output | CNT_W | Ready withdrawals before a transfer, saturating |

## Verification
The main function is exercised with four patterns. Hand-built stalls that drop valid, change data, or do both show that the two cause bits are independent. Ready toggling under an idle valid, together with valid and ready arriving in each order, separates legal retraction from a real violation. A long random stream of legal handshakes, compared against a bench model of every counter, shows that backpressure, throttling and retraction are counted apart and that no false error is raised. A clear in the middle of traffic and a run past counter saturation cover the boundaries.

// File: rtl/axis_mon_pkg.sv
package axis_mon_pkg;
  localparam int CAUSE_W = 2;
  localparam int NUM_CNT = 4;
  // counter slots
  localparam int CNT_XFER    = 0;
  localparam int CNT_BP      = 1;
  localparam int CNT_THR     = 2;
  localparam int CNT_RETRACT = 3;

  typedef struct packed {
    logic clr;
    logic xfer;
    logic bpStall;
    logic thrStall;
    logic retract;
  } monStrobeT;
endpackage

// File: rtl/axis_mon_satcnt.sv
module axis_mon_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        value <= '0;
    else if (clr)                     value <= '0;
    else if (inc && value != MAX_VAL) value <= value + 1'b1;
  end
endmodule

// File: rtl/axis_mon_datapath.sv
module axis_mon_datapath
  import axis_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [DATA_W-1:0]              tData,
  input  monStrobeT                      strobes,
  output logic                           dataDiff,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  cntVals
);
  logic [DATA_W-1:0]  prevData;
  logic [NUM_CNT-1:0] incVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevData <= '0;
    else       prevData <= tData;
  end

  assign dataDiff = (tData != prevData);

  always_comb begin
    incVec              = '0;
    incVec[CNT_XFER]    = strobes.xfer;
    incVec[CNT_BP]      = strobes.bpStall;
    incVec[CNT_THR]     = strobes.thrStall;
    incVec[CNT_RETRACT] = strobes.retract;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    axis_mon_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strobes.clr),
      .inc  (incVec[i]),
      .value(cntVals[i])
    );
  end
endmodule

// File: rtl/axis_mon_ctrl.sv
module axis_mon_ctrl
  import axis_mon_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               tValid,
  input  logic               tReady,
  input  logic               dataDiff,
  output monStrobeT          strobes,
  output logic               errPulse,
  output logic [CAUSE_W-1:0] errCause,
  output logic               errSticky
);
  logic prevValid, prevReady;
  logic stallPrev, waitPrev;
  logic validDrop, dataChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevReady <= 1'b0;
    end else begin
      prevValid <= tValid;
      prevReady <= tReady;
    end
  end

  assign stallPrev  = prevValid & ~prevReady;
  assign waitPrev   = ~prevValid & prevReady;
  assign validDrop  = stallPrev & ~tValid;
  assign dataChange = stallPrev & dataDiff;

  always_comb begin
    strobes.clr      = clear;
    strobes.xfer     = tValid & tReady;
    strobes.bpStall  = tValid & ~tReady;
    strobes.thrStall = ~tValid & tReady;
    strobes.retract  = waitPrev & ~tReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse  <= 1'b0;
      errCause  <= '0;
      errSticky <= 1'b0;
    end else if (clear) begin
      errPulse  <= 1'b0;
      errCause  <= '0;
      errSticky <= 1'b0;
    end else begin
      errPulse  <= validDrop | dataChange;
      errCause  <= {dataChange, validDrop};
      if (validDrop | dataChange) errSticky <= 1'b1;
    end
  end
endmodule

// File: rtl/axis_hs_monitor.sv
module axis_hs_monitor
  import axis_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              tValid,
  input  logic              tReady,
  input  logic [DATA_W-1:0] tData,
  output logic              errSticky,
  output logic              errPulse,
  output logic [1:0]        errCause,
  output logic [CNT_W-1:0]  xferCount,
  output logic [CNT_W-1:0]  bpStallCount,
  output logic [CNT_W-1:0]  thrStallCount,
  output logic [CNT_W-1:0]  retractCount
);
  monStrobeT                     strobes;
  logic                          dataDiff;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVals;

  axis_mon_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .tValid   (tValid),
    .tReady   (tReady),
    .dataDiff (dataDiff),
    .strobes  (strobes),
    .errPulse (errPulse),
    .errCause (errCause),
    .errSticky(errSticky)
  );

  axis_mon_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tData   (tData),
    .strobes (strobes),
    .dataDiff(dataDiff),
    .cntVals (cntVals)
  );

  assign xferCount     = cntVals[CNT_XFER];
  assign bpStallCount  = cntVals[CNT_BP];
  assign thrStallCount = cntVals[CNT_THR];
  assign retractCount  = cntVals[CNT_RETRACT];
endmodule

// File: rtl/axis_hs_monitor_chk.sv
module axis_hs_monitor_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              tValid,
  input logic              tReady,
  input logic [DATA_W-1:0] tData,
  input logic              errSticky,
  input logic              errPulse,
  input logic [1:0]        errCause,
  input logic [CNT_W-1:0]  xferCount,
  input logic [CNT_W-1:0]  bpStallCount,
  input logic [CNT_W-1:0]  thrStallCount,
  input logic [CNT_W-1:0]  retractCount
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;
  logic live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (live && $past(tValid && !tReady) && !tValid && !clear) |=> (errPulse && errCause[0]));

  assert_data_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    (live && $past(tValid && !tReady) && (tData != $past(tData)) && !clear)
      |=> (errPulse && errCause[1]));

  assert_no_false_error_R4: assert property (@(posedge clk) disable iff (!rstN)
    (live && !$past(tValid && !tReady)) |=> !errPulse);

  assert_cause_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |-> (errCause == 2'b00));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !clear) |=> errSticky);

  assert_pulse_sets_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errSticky);

  assert_xfer_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tValid && tReady && !clear && xferCount != MAX_VAL)
      |=> (xferCount == $past(xferCount) + 1'b1));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xferCount == MAX_VAL && !clear) |=> (xferCount == MAX_VAL));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (xferCount == '0 && bpStallCount == '0 && thrStallCount == '0
               && retractCount == '0 && !errSticky && !errPulse));
endmodule

bind axis_hs_monitor axis_hs_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_axis_hs_monitor.sv
module tb_axis_hs_monitor;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN, clear, tValid, tReady;
  logic [DATA_W-1:0] tData;
  logic errSticky, errPulse;
  logic [1:0] errCause;
  logic [CNT_W-1:0] xferCount, bpStallCount, thrStallCount, retractCount;

  always #5 clk = ~clk;

  axis_hs_monitor #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

  typedef struct {
    int xfer; int bp; int thr; int ret;
    bit sticky; bit pulse; bit [1:0] cause;
    string tag;
  } expT;
  expT expQ[$];

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model state
  bit mPv, mPr;
  logic [DATA_W-1:0] mPd;
  int mX, mB, mT, mR;
  bit mSticky, mPulse;
  bit [1:0] mCause;

  function automatic int satInc(int v);
    return (v < MAXC) ? v + 1 : v;
  endfunction

  // apply one cycle of stimulus just after a falling edge, predict the state after the next rise
  task automatic step(bit v, bit r, logic [DATA_W-1:0] d, bit clr, string tag);
    bit stallP, vd, dc;
    expT e;
    tValid = v; tReady = r; tData = d; clear = clr;
    stallP = mPv && !mPr;
    vd = stallP && !v;
    dc = stallP && (d != mPd);
    if (clr) begin
      mX = 0; mB = 0; mT = 0; mR = 0;
      mSticky = 0; mPulse = 0; mCause = 0;
    end else begin
      if (v && r)  mX = satInc(mX);
      if (v && !r) mB = satInc(mB);
      if (!v && r) mT = satInc(mT);
      if (!mPv && mPr && !r) mR = satInc(mR);
      mPulse = vd || dc;
      mCause = {dc, vd};
      if (mPulse) mSticky = 1;
    end
    mPv = v; mPr = r; mPd = d;
    e.xfer = mX; e.bp = mB; e.thr = mT; e.ret = mR;
    e.sticky = mSticky; e.pulse = mPulse; e.cause = mCause; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // scoreboard monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      total++;
      if (xferCount != e.xfer[CNT_W-1:0] || bpStallCount != e.bp[CNT_W-1:0] ||
          thrStallCount != e.thr[CNT_W-1:0] || retractCount != e.ret[CNT_W-1:0] ||
          errSticky != e.sticky || errPulse != e.pulse || errCause != e.cause) begin
        fails++;
        $display("FAIL %s: got x=%0d bp=%0d thr=%0d ret=%0d st=%0b p=%0b c=%0d exp x=%0d bp=%0d thr=%0d ret=%0d st=%0b p=%0b c=%0d",
                 e.tag, xferCount, bpStallCount, thrStallCount, retractCount, errSticky, errPulse, errCause,
                 e.xfer, e.bp, e.thr, e.ret, e.sticky, e.pulse, e.cause);
      end
    end
  end

  task automatic randomLegal(int n);
    bit v = 0;
    logic [DATA_W-1:0] d = '0;
    for (int i = 0; i < n; i++) begin
      bit r;
      if (!v && ($urandom % 2)) begin v = 1; d = $urandom; end
      r = $urandom % 2;
      step(v, r, d, 0, "R4");
      if (v && r) begin
        v = $urandom % 2;
        d = $urandom;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rstN = 0; clear = 0; tValid = 1; tReady = 0; tData = 32'hA5;
    mPv = 0; mPr = 0; mPd = '0;
    mX = 0; mB = 0; mT = 0; mR = 0; mSticky = 0; mPulse = 0; mCause = 0;
    void'($urandom(17));
    repeat (3) @(negedge clk);
    total++;
    if (xferCount != 0 || bpStallCount != 0 || thrStallCount != 0 || retractCount != 0 ||
        errSticky || errPulse || errCause != 0) begin
      fails++;
      $display("FAIL R11: got nonzero outputs in reset exp all zero");
    end
    rstN = 1;
    // R11: valid drops right after reset although it was high during reset: no violation
    step(0, 0, 32'h0, 0, "R11");
    step(0, 0, 32'h0, 0, "R11");
    // R1: back-to-back transfers
    step(1, 1, 32'h11, 0, "R1");
    step(1, 1, 32'h12, 0, "R1");
    step(1, 1, 32'h13, 0, "R1");
    // R5 then legal completion: valid first, ready later
    step(1, 0, 32'h20, 0, "R5");
    step(1, 0, 32'h20, 0, "R5");
    step(1, 1, 32'h20, 0, "R4");
    // R6 and R7: ready first, withdrawn, ready again, valid joins
    step(0, 1, 32'h0, 0, "R6");
    step(0, 0, 32'h0, 0, "R7");
    step(0, 1, 32'h0, 0, "R6");
    step(1, 1, 32'h30, 0, "R4");
    // R4: both rise in the same cycle after idle
    step(0, 0, 32'h0, 0, "R4");
    step(1, 1, 32'h31, 0, "R4");
    step(0, 0, 32'h0, 0, "R4");
    // R2: stall then valid dropped with data held
    step(1, 0, 32'h40, 0, "R5");
    step(0, 0, 32'h40, 0, "R2");
    step(0, 0, 32'h40, 0, "R8");
    // R8 sticky survives clean traffic
    step(1, 1, 32'h41, 0, "R8");
    step(0, 0, 32'h41, 0, "R8");
    // R10 clear
    step(0, 0, 32'h41, 1, "R10");
    // R3 data changed while stalled
    step(1, 0, 32'h50, 0, "R5");
    step(1, 0, 32'h51, 0, "R3");
    step(1, 1, 32'h51, 0, "R3");
    // R3 both causes at once
    step(1, 0, 32'h60, 0, "R5");
    step(0, 0, 32'h61, 0, "R3");
    step(0, 0, 32'h61, 0, "R3");
    // R10 clear discards a simultaneous violation
    step(1, 0, 32'h70, 0, "R5");
    step(0, 1, 32'h70, 1, "R10");
    step(0, 0, 32'h70, 0, "R10");
    // legal random handshakes
    randomLegal(3000);
    // R9 saturation of the transfer counter
    step(0, 0, 32'h0, 1, "R10");
    for (int i = 0; i < MAXC + 5; i++) step(1, 1, i, 0, "R9");
    step(0, 0, 32'h0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule